// File: doc/BRIEF.md
# Masked Sticky Event Recorder

This block keeps one port's record of error events for a repeater. While a packet is being repeated, raw event strobes are collected into a hidden staging register. Some of those strobes are qualified by other conditions seen in the same packet. When the packet ends, the staged events pass through an 8-bit enable mask and are ORed into a host-visible sticky register. The register is cleared only by a host read.

The host sees the register on `rdData` and pulses `rdStb` to consume it. The pulse clears every bit that was shown. A commit that lands in the same cycle as the read, or in the cycle after it, is kept. Any set bit drives `flagFound`. The interrupt output follows `flagFound` while `irqEn` is high.

Bit map, which both the raw inputs and the register use:

| Bit | Event |
|-----|-------|
| 0 | jabber protection entered |
| 1 | elasticity buffer error |
| 2 | phase-lock error |
| 3 | collision outside the slot time |
| 4 | port partitioned |
| 5 | link lost on a twisted-pair port |
| 6 | short event (raw input means the packet was shorter than 74 bits) |
| 7 | reserved |

Top module: `sticky_event_recorder`

## Requirements
- R1: After reset, the register reads 0x00, the mask is 0x00, and `flagFound` and `irq` are low.
- R2: Events seen during a packet do not appear on `rdData` before the end-of-packet cycle. They appear in the cycle after `pktEnd` is sampled.
- R3: At commit, a staged event is recorded only if its mask bit is set. Staged events whose mask bit is clear are dropped.
- R4: The elasticity error (bit 1) is dropped if a collision is seen in any cycle of the packet, including the end cycle. It is also dropped if a phase-lock error (bit 2) was seen in an earlier cycle or in the same cycle. An elasticity error seen before the phase-lock error is kept.
- R5: The short event (bit 6) is recorded only if no collision was seen during the packet.
- R6: A cycle with `rdStb` high returns the current register on `rdData` and clears it. Bits committed in that same cycle, or in the next cycle, remain set.
- R7: Recorded bits are sticky. Later packets OR new bits in, and without a read nothing clears.
- R8: `flagFound` is the OR of all register bits. `irq` equals `flagFound` gated by `irqEn`.
- R9: Event strobes outside a packet are ignored. The staging register clears when each packet starts.
- R10: A mask write takes effect at the next commit. A write in the same cycle as `pktEnd` does not affect that commit.
- R11: Event bits map as given in the table above. Bit 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pktStart | input | 1 | Packet repetition begins |
| pktEnd | input | 1 | Packet transmission ends; commit point |
| evIn | input | 8 | Raw event strobes, bit map as above |
| collision | input | 1 | Collision seen in this cycle |
| maskWe | input | 1 | Mask write strobe |
| maskIn | input | 8 | New mask value |
| irqEn | input | 1 | Interrupt enable |
| rdStb | input | 1 | Host read; clears the register |
| rdData | output | 8 | Visible event register |
| flagFound | output | 1 | Any recorded bit set |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `pktStart` and `pktEnd` never arrive in the same cycle. They also assume that `pktEnd` comes only after a `pktStart`, so packets are framed cleanly. The stimulus keeps to this: every packet is a start pulse, one or more event cycles, and a separate end pulse. Reads and mask writes are placed freely around those pulses, including on the end cycle itself. That placement exercises the read/commit and mask/commit orderings.

// File: rtl/evrec_pkg.sv
package evrec_pkg;
  localparam int REG_W     = 8;
  localparam int BIT_JAB   = 0;
  localparam int BIT_ELAS  = 1;
  localparam int BIT_PLL   = 2;
  localparam int BIT_LATE  = 3;
  localparam int BIT_PART  = 4;
  localparam int BIT_LINK  = 5;
  localparam int BIT_SHORT = 6;
  localparam int NUM_EV    = 7;

  typedef struct packed {
    logic clearStage;
    logic gather;
    logic commit;
  } ctrlStrobes_t;
endpackage

// File: rtl/evrec_ctrl.sv
module evrec_ctrl
  import evrec_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         pktStart,
  input  logic         pktEnd,
  output ctrlStrobes_t strobes,
  output logic         inPacket
);
  typedef enum logic {IDLE, ACTIVE} state_t;
  state_t state, nextState;

  always_comb begin
    strobes   = '0;
    nextState = state;
    case (state)
      IDLE: begin
        if (pktStart) begin
          strobes.clearStage = 1'b1;
          nextState          = ACTIVE;
        end
      end
      ACTIVE: begin
        strobes.gather = 1'b1;
        if (pktEnd) begin
          strobes.commit = 1'b1;
          nextState      = IDLE;
        end
      end
      default: nextState = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= IDLE;
    else       state <= nextState;
  end

  assign inPacket = (state == ACTIVE);

  // R2
  commit_ends_packet_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> !inPacket);

  // R9
  start_opens_packet_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearStage |=> inPacket);

  // R9
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.clearStage, strobes.commit}));
endmodule

// File: rtl/evrec_datapath.sv
module evrec_datapath
  import evrec_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic [W-1:0] evIn,
  input  logic         collision,
  input  logic         maskWe,
  input  logic [W-1:0] maskIn,
  input  logic         rdStb,
  output logic [W-1:0] recReg
);
  localparam logic [W-1:0] VALID_MASK = W'((1 << NUM_EV) - 1);

  logic [W-1:0] stageReg, maskReg, newEv, stageNext, commitBits;
  logic         collSeen, collNext;

  always_comb begin
    newEv = evIn & VALID_MASK;
    newEv[BIT_ELAS] = evIn[BIT_ELAS] & ~(stageReg[BIT_PLL] | evIn[BIT_PLL]);
    stageNext = stageReg | newEv;
    collNext  = collSeen | collision;
    commitBits = stageNext;
    commitBits[BIT_ELAS]  = stageNext[BIT_ELAS]  & ~collNext;
    commitBits[BIT_SHORT] = stageNext[BIT_SHORT] & ~collNext;
    commitBits = commitBits & maskReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageReg <= '0;
      collSeen <= 1'b0;
    end else if (strobes.clearStage) begin
      stageReg <= '0;
      collSeen <= 1'b0;
    end else if (strobes.gather) begin
      stageReg <= stageNext;
      collSeen <= collNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)       maskReg <= '0;
    else if (maskWe) maskReg <= maskIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) recReg <= '0;
    else       recReg <= (rdStb ? '0 : recReg) | (strobes.commit ? commitBits : '0);
  end

  // R6
  read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && !strobes.commit) |=> (recReg == '0));

  // R6
  commit_survives_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> ((recReg & $past(commitBits)) == $past(commitBits)));

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rdStb && !strobes.commit) |=> $stable(recReg));

  // R3
  only_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && rdStb) |=> ((recReg & ~$past(maskReg)) == '0));
endmodule

// File: rtl/sticky_event_recorder.sv
module sticky_event_recorder
  import evrec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pktStart,
  input  logic       pktEnd,
  input  logic [7:0] evIn,
  input  logic       collision,
  input  logic       maskWe,
  input  logic [7:0] maskIn,
  input  logic       irqEn,
  input  logic       rdStb,
  output logic [7:0] rdData,
  output logic       flagFound,
  output logic       irq
);
  ctrlStrobes_t strobes;
  logic         inPacket;
  logic [7:0]   recReg;

  evrec_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .pktStart(pktStart), .pktEnd(pktEnd),
    .strobes(strobes), .inPacket(inPacket)
  );

  evrec_datapath #(.W(8)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .evIn(evIn),
    .collision(collision), .maskWe(maskWe), .maskIn(maskIn),
    .rdStb(rdStb), .recReg(recReg)
  );

  assign rdData    = recReg;
  assign flagFound = |recReg;
  assign irq       = flagFound & irqEn;

  // R8
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagFound) |-> $past(rdStb));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inPacket && !rdStb) |=> (recReg == $past(recReg)));
endmodule

// File: tb/sticky_event_recorder_tb.sv
module sticky_event_recorder_tb_top;
  logic       clk = 1'b0;
  logic       rstN, pktStart, pktEnd, collision, maskWe, irqEn, rdStb;
  logic [7:0] evIn, maskIn, rdData;
  logic       flagFound, irq;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sticky_event_recorder dut_i (
    .clk(clk), .rstN(rstN), .pktStart(pktStart), .pktEnd(pktEnd),
    .evIn(evIn), .collision(collision), .maskWe(maskWe), .maskIn(maskIn),
    .irqEn(irqEn), .rdStb(rdStb), .rdData(rdData), .flagFound(flagFound),
    .irq(irq)
  );

  // fields: mask, ev1, coll1, ev2, coll2, expected
  localparam logic [33:0] VEC [0:10] = '{
    {8'hFF, 8'h01, 1'b0, 8'h00, 1'b0, 8'h01},  // R11 jabber
    {8'hFF, 8'h3C, 1'b0, 8'h00, 1'b0, 8'h3C},  // R11 bits 2..5
    {8'hFF, 8'h02, 1'b0, 8'h00, 1'b1, 8'h00},  // R4 late collision
    {8'hFF, 8'h06, 1'b0, 8'h00, 1'b0, 8'h04},  // R4 same-cycle pll
    {8'hFF, 8'h02, 1'b0, 8'h04, 1'b0, 8'h06},  // R4 elastic first
    {8'hFF, 8'h04, 1'b0, 8'h02, 1'b0, 8'h04},  // R4 pll first
    {8'hFF, 8'h40, 1'b0, 8'h00, 1'b0, 8'h40},  // R5 short
    {8'hFF, 8'h40, 1'b0, 8'h00, 1'b1, 8'h00},  // R5 short with coll
    {8'h0F, 8'h7F, 1'b0, 8'h00, 1'b0, 8'h0D},  // R3 partial mask
    {8'hFF, 8'h80, 1'b0, 8'h00, 1'b0, 8'h00},  // R11 reserved bit
    {8'hF0, 8'h51, 1'b1, 8'h00, 1'b0, 8'h10}   // R3 mask plus R5
  };

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic writeMask(logic [7:0] m);
    maskIn = m; maskWe = 1'b1; nxt(); maskWe = 1'b0;
  endtask

  task automatic packet(logic [7:0] e1, logic c1, logic [7:0] e2, logic c2);
    pktStart = 1'b1; nxt(); pktStart = 1'b0;
    evIn = e1; collision = c1; nxt();
    evIn = e2; collision = c2; nxt();
    evIn = '0; collision = 1'b0; pktEnd = 1'b1; nxt(); pktEnd = 1'b0;
  endtask

  task automatic hostRead();
    rdStb = 1'b1; nxt(); rdStb = 1'b0;
  endtask

  initial begin
    rstN = 0; pktStart = 0; pktEnd = 0; collision = 0; maskWe = 0;
    irqEn = 0; rdStb = 0; evIn = '0; maskIn = '0;
    repeat (3) nxt();
    rstN = 1; nxt();

    // R1 reset state
    check("R1 reg", rdData, 8'h00);
    check("R1 flag/irq", {6'b0, flagFound, irq}, 8'h00);
    packet(8'h01, 0, 8'h00, 0);
    check("R1 mask zero", rdData, 8'h00);

    for (int i = 0; i < 11; i++) begin
      writeMask(VEC[i][33:26]);
      packet(VEC[i][25:18], VEC[i][17], VEC[i][16:9], VEC[i][8]);
      check($sformatf("vector %0d (R3/R4/R5/R11)", i), rdData, VEC[i][7:0]);
      hostRead();
      check("R6 cleared", rdData, 8'h00);
    end

    // R2 not visible before commit
    writeMask(8'hFF);
    pktStart = 1; nxt(); pktStart = 0;
    evIn = 8'h01; nxt(); evIn = 8'h00;
    pktEnd = 1;
    check("R2 before commit", rdData, 8'h00);
    nxt(); pktEnd = 0;
    check("R2 after commit", rdData, 8'h01);

    // R7 sticky accumulation
    packet(8'h20, 0, 8'h00, 0);
    check("R7 sticky", rdData, 8'h21);

    // R8 flag and irq
    check("R8 irq off", {6'b0, flagFound, irq}, 8'h02);
    irqEn = 1; nxt();
    check("R8 irq on", {6'b0, flagFound, irq}, 8'h03);
    hostRead();
    check("R8 cleared", {6'b0, flagFound, irq}, 8'h00);
    irqEn = 0;

    // R6 read and commit in the same cycle
    packet(8'h01, 0, 8'h00, 0);
    pktStart = 1; nxt(); pktStart = 0;
    evIn = 8'h08; nxt(); evIn = 8'h00;
    pktEnd = 1; rdStb = 1;
    check("R6 read data", rdData, 8'h01);
    nxt(); pktEnd = 0; rdStb = 0;
    check("R6 same-cycle commit", rdData, 8'h08);

    // R6 commit right after a read
    pktStart = 1; nxt(); pktStart = 0;
    evIn = 8'h10; nxt(); evIn = 8'h00;
    rdStb = 1; nxt(); rdStb = 0;
    check("R6 read before end", rdData, 8'h00);
    pktEnd = 1; nxt(); pktEnd = 0;
    check("R6 next-cycle commit", rdData, 8'h10);
    hostRead();

    // R9 events outside a packet ignored, staging cleared at start
    evIn = 8'h3D; collision = 1; nxt(); evIn = 8'h00; collision = 0;
    check("R9 idle events", rdData, 8'h00);
    packet(8'h00, 0, 8'h40, 0);
    check("R9 stage cleared", rdData, 8'h40);
    hostRead();

    // R10 mask write on commit cycle uses old mask
    pktStart = 1; nxt(); pktStart = 0;
    evIn = 8'h01; nxt(); evIn = 8'h00;
    pktEnd = 1; maskWe = 1; maskIn = 8'h00; nxt(); pktEnd = 0; maskWe = 0;
    check("R10 old mask", rdData, 8'h01);
    hostRead();
    packet(8'h01, 0, 8'h00, 0);
    check("R10 new mask", rdData, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule